// File: doc/BRIEF.md
# Background Offset and Gain Trim Integrator

This block is the digital half of a self-calibrating conversion section. The schedule of the section opens two kinds of calibration slot. In a zero slot the comparator judges its response to a zero reference. In a gain slot it judges the gain error against one of two ladder references, the coarse (MSB) reference or the fine (LSB) reference. On each such slot the block receives a single error sign. It nudges the matching correction register by one fractional step in the direction that sign asks for.

Each correction register is a signed two's-complement word with `FRAC_BITS` bits below one output LSB. A single step therefore moves the correction by only a fraction of an LSB, and many samples must agree before the correction moves by a whole code. The registers saturate at their limits instead of wrapping. The loop runs from reset onward for as long as the clock runs. A separate counter raises a sticky `calibrated` flag once the minimum settling interval of clock cycles has passed since reset release.

The correction DACs that turn the codes into voltages, and the analog error measurement, live outside this block. `rst_n` is asserted asynchronously and is expected to be released synchronously to `clk` by the reset tree.

Top module: `bgcal_trim_loop`

## Requirements
- R1: While `rst_n` is low, `offset_code`, `gain_code_msb` and `gain_code_lsb` are 0 and `calibrated` is 0.
- R2: On a rising edge with `zero_slot_en`=1, `offset_code` changes by +1 when `err_up`=1 and by -1 when `err_up`=0. One unit is 1/2^FRAC_BITS of an output LSB (1/16 with the default FRAC_BITS=4).
- R3: On a rising edge with `zero_slot_en`=0, `offset_code` keeps its value.
- R4: On a rising edge with `gain_slot_en`=1, the gain code picked by `gain_ref_sel` (0 selects `gain_code_msb`, 1 selects `gain_code_lsb`) changes by +1 for `err_up`=1 and by -1 for `err_up`=0. The other gain code keeps its value.
- R5: On a rising edge with `gain_slot_en`=0, both gain codes keep their values.
- R6: Every code is a CODE_W-bit two's-complement value (default 10 bits, range -512 to +511). A step up at the maximum leaves the code at the maximum, and a step down at the minimum leaves it at the minimum.
- R7: When both slot enables are high in the same cycle, the offset code and the selected gain code each take their step, both in the direction of the one `err_up` value.
- R8: `calibrated` stays 0 until SETTLE_CYCLES rising edges (default 10000) have passed since reset release. It is 1 from that edge on and stays 1 until the next reset.
- R9: After `calibrated` is 1, the codes go on following R2 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; every update happens on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| zero_slot_en | input | 1 | Zero-reference (offset) calibration slot is active |
| gain_slot_en | input | 1 | Gain calibration slot is active |
| gain_ref_sel | input | 1 | Reference judged in the gain slot: 0 coarse, 1 fine |
| err_up | input | 1 | Error sign: 1 asks for a larger code, 0 for a smaller code |
| offset_code | output | CODE_W | Signed offset correction, fractional LSB units |
| gain_code_msb | output | CODE_W | Signed gain correction for the coarse reference |
| gain_code_lsb | output | CODE_W | Signed gain correction for the fine reference |
| calibrated | output | 1 | Minimum settling interval has passed since reset |

## Verification
Long directed runs of one error sign drive each register into both saturation limits, so a clamp can be told apart from a wraparound or an off-by-one limit. Seeded random mixes of slot enables, reference selects and error signs show whether each register moves only in its own slot, whether a gain step reaches the wrong reference, and whether an offset step taken in the same cycle as a gain step is lost. An idle stretch that crosses the settling boundary looks at `calibrated` on the edge just before the threshold and on the threshold edge itself. Random traffic after that shows that calibration goes on once the flag is up.

// File: rtl/bgcal_pkg.sv
package bgcal_pkg;
  typedef enum logic {
    REF_COARSE = 1'b0,
    REF_FINE   = 1'b1
  } gain_ref_e;

  localparam int GAIN_REFS = 2;
endpackage

// File: rtl/bgcal_accum.sv
module bgcal_accum #(
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_en,
  input  logic                     step_up,
  output logic signed [CODE_W-1:0] code
);
  localparam logic signed [CODE_W-1:0] MAXV = {1'b0, {(CODE_W-1){1'b1}}};
  localparam logic signed [CODE_W-1:0] MINV = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic signed [CODE_W-1:0] ONE  = {{(CODE_W-1){1'b0}}, 1'b1};

  logic signed [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (step_en) begin
      if (step_up) begin
        if (code_q != MAXV) code_d = code_q + ONE;
      end else begin
        if (code_q != MINV) code_d = code_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code = code_q;

  // R3 / R5: no slot, no movement
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(code_q));
  // R2 / R4: single fractional step up
  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && code_q != MAXV) |=> (code_q == $past(code_q) + ONE));
  // R2 / R4: single fractional step down
  p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && code_q != MINV) |=> (code_q == $past(code_q) - ONE));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && code_q == MAXV) |=> (code_q == MAXV));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && code_q == MINV) |=> (code_q == MINV));
endmodule

// File: rtl/bgcal_settle.sv
module bgcal_settle #(
  parameter int SETTLE_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic settled
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  assign cnt_en = (cnt_q != LIMIT);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (cnt_en) begin
      cnt_d = cnt_q + CNT_ONE;
      if (cnt_q == LAST) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign settled = done_q;

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  p_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && cnt_q != LAST) |=> !done_q);
  p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/bgcal_trim_loop.sv
module bgcal_trim_loop
  import bgcal_pkg::*;
#(
  parameter int CODE_W        = 10,
  parameter int FRAC_BITS     = 4,
  parameter int SETTLE_CYCLES = 10000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     zero_slot_en,
  input  logic                     gain_slot_en,
  input  logic                     gain_ref_sel,
  input  logic                     err_up,
  output logic signed [CODE_W-1:0] offset_code,
  output logic signed [CODE_W-1:0] gain_code_msb,
  output logic signed [CODE_W-1:0] gain_code_lsb,
  output logic                     calibrated
);
  localparam int INT_BITS = CODE_W - FRAC_BITS;

  initial begin
    if (INT_BITS < 1) $error("CODE_W must exceed FRAC_BITS");
  end

  logic signed [CODE_W-1:0] gain_codes [GAIN_REFS];
  gain_ref_e                ref_sel;

  assign ref_sel = gain_ref_e'(gain_ref_sel);

  bgcal_accum #(.CODE_W(CODE_W)) u_offset (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (zero_slot_en),
    .step_up (err_up),
    .code    (offset_code)
  );

  for (genvar g = 0; g < GAIN_REFS; g++) begin : g_gain
    logic pick;
    assign pick = gain_slot_en && (ref_sel == gain_ref_e'(g));
    bgcal_accum #(.CODE_W(CODE_W)) u_gain (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (pick),
      .step_up (err_up),
      .code    (gain_codes[g])
    );
  end

  assign gain_code_msb = gain_codes[REF_COARSE];
  assign gain_code_lsb = gain_codes[REF_FINE];

  bgcal_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .settled (calibrated)
  );

  p_coarse_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_slot_en && ref_sel == REF_COARSE) |=> $stable(gain_code_lsb));
  p_fine_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_slot_en && ref_sel == REF_FINE) |=> $stable(gain_code_msb));
  p_gain_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_slot_en |=> ($stable(gain_code_msb) && $stable(gain_code_lsb)));
endmodule

// File: tb/bgcal_trim_loop_tb_top.sv
module bgcal_trim_loop_tb_top;
  localparam int CODE_W = 10;
  localparam int SETTLE = 10000;
  localparam int MAXC   = (1 << (CODE_W - 1)) - 1;
  localparam int MINC   = -(1 << (CODE_W - 1));

  logic clk = 1'b0;
  logic rst_n;
  logic zero_slot_en, gain_slot_en, gain_ref_sel, err_up;
  logic signed [CODE_W-1:0] offset_code, gain_code_msb, gain_code_lsb;
  logic calibrated;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  int m_off = 0, m_gm = 0, m_gl = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bgcal_trim_loop #(.CODE_W(CODE_W), .FRAC_BITS(4), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .zero_slot_en(zero_slot_en), .gain_slot_en(gain_slot_en),
    .gain_ref_sel(gain_ref_sel), .err_up(err_up), .offset_code(offset_code),
    .gain_code_msb(gain_code_msb), .gain_code_lsb(gain_code_lsb), .calibrated(calibrated));

  function automatic int sat_step(int cur, bit up);
    if (up) return (cur == MAXC) ? cur : cur + 1;
    return (cur == MINC) ? cur : cur - 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; drives, passes one rising edge, checks at the next falling edge
  task automatic cyc(bit z, bit g, bit sel, bit up);
    string t_off, t_gain;
    bit    sat_o, sat_g;
    int    gcur;
    zero_slot_en = z; gain_slot_en = g; gain_ref_sel = sel; err_up = up;
    gcur  = sel ? m_gl : m_gm;
    sat_o = z && ((up && m_off == MAXC) || (!up && m_off == MINC));
    sat_g = g && ((up && gcur == MAXC) || (!up && gcur == MINC));
    if (z) m_off = sat_step(m_off, up);
    if (g && !sel) m_gm = sat_step(m_gm, up);
    if (g && sel)  m_gl = sat_step(m_gl, up);
    @(negedge clk);
    ecount++;
    if (ecount > SETTLE)  t_off = "R9";
    else if (sat_o)       t_off = "R6";
    else if (z && g)      t_off = "R7";
    else if (z)           t_off = "R2";
    else                  t_off = "R3";
    if (ecount > SETTLE)  t_gain = "R9";
    else if (sat_g)       t_gain = "R6";
    else if (z && g)      t_gain = "R7";
    else if (g)           t_gain = "R4";
    else                  t_gain = "R5";
    check(t_off,  "offset_code",   int'(offset_code),   m_off);
    check(t_gain, "gain_code_msb", int'(gain_code_msb), m_gm);
    check(t_gain, "gain_code_lsb", int'(gain_code_lsb), m_gl);
    check("R8", "calibrated", int'(calibrated), (ecount >= SETTLE) ? 1 : 0);
  endtask

  task automatic check_reset();
    check("R1", "offset_code reset",   int'(offset_code),   0);
    check("R1", "gain_code_msb reset", int'(gain_code_msb), 0);
    check("R1", "gain_code_lsb reset", int'(gain_code_lsb), 0);
    check("R1", "calibrated reset",    int'(calibrated),    0);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'h00C0_FFEE;
    void'($urandom(seed));
    rst_n = 1'b0;
    zero_slot_en = 1'b0; gain_slot_en = 1'b0; gain_ref_sel = 1'b0; err_up = 1'b0;
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    ecount = 0;

    // R6: drive the offset into both limits
    for (int i = 0; i < 520; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1);
    check("R6", "offset at max", int'(offset_code), MAXC);
    for (int i = 0; i < 1030; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check("R6", "offset at min", int'(offset_code), MINC);
    // R4 / R6: coarse gain up to max, fine gain down to min
    for (int i = 0; i < 520; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 520; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
    check("R6", "gain msb at max", int'(gain_code_msb), MAXC);
    check("R6", "gain lsb at min", int'(gain_code_lsb), MINC);
    // R7: both slots together
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b1, i[0], i[1]);
    // R3 / R5: idle slots with toggling sign must not move anything
    for (int i = 0; i < 50; i++) cyc(1'b0, 1'b0, i[0], i[1]);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      cyc(r[0] & r[1], r[2] & r[3], r[4], r[5]);
    end
    // R8: idle across the settling boundary
    while (ecount < SETTLE + 2) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    // R9: calibration continues after the flag
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom;
      cyc(r[0], r[1], r[2], r[3]);
    end
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1);
    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check_reset();
    @(negedge clk);
    check_reset();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule